// File: doc/BRIEF.md
# Mailbox Command Responder

This block is the management-side end of a 16-byte host mailbox. The host fills the request bytes and then pulses a doorbell. The responder takes a copy of the command, the sequence number and the argument bytes on that doorbell edge. In the next cycle it decodes the command, updates the single flash window it tracks, and writes the response bytes, the echoed sequence number and a response code in one clock edge. It then pulses the host interrupt for one cycle and goes back to idle.

Flash geometry, window sizes, the API version and the bus base block of the window are parameters. Real flash access, address translation and write-back are not modelled, so a flush completes at once.

The block also holds the management-owned event byte. Management logic sets bits in it through a pulse input. The host clears bits in it with an acknowledge command.

Byte roles used throughout:
- byte 0: command code
- byte 1: sequence number
- bytes 2 to 12: arguments 0 to 10, multi-byte values least significant byte first
- byte 13: response code
- byte 14: host status
- byte 15: event byte

Top module: `mbx_responder`

## Requirements
- R1: After a synchronous active-low reset, bytes 0 to 14 read 0x00 and byte 15 reads 0x01 (bit 0 is the restart flag). `host_irq` and `busy` are low, and no window is open.
- R2: A doorbell sampled while idle raises `busy` from the next cycle. `host_irq` is high for exactly one cycle, two cycles after the doorbell edge, and `busy` falls with it. Doorbells sampled while `busy` is high are ignored.
- R3: The response writes the sequence number sampled at the doorbell edge into byte 1 and a code into byte 13: 1 for success, 2 for parameter error. In the response cycle these writes take priority over a host write to the same byte.
- R4: Command 2 returns four values, each least significant byte first:
  - argument 0: the API version
  - arguments 1 to 2: the read window size in blocks
  - arguments 3 to 4: the write window size in blocks
  - argument 5: log2 of the block size

  It returns code 1.
- R5: Command 3 returns the flash size in bytes in arguments 0 to 3 and the erase granule in bytes in arguments 4 to 7, both least significant byte first, with code 1.
- R6: Command 4 opens a read window and command 6 opens a write window. Each replaces any open window, takes a 16-bit block offset from arguments 0 to 1, and returns the base block plus the offset in arguments 0 to 1 with code 1. An offset equal to or beyond the flash size in blocks returns code 2, leaves the window unchanged and leaves the argument bytes untouched.
- R7: Commands 7 (mark dirty) and 8 (flush) return code 1 when a write window is open. Otherwise they return code 2.
- R8: Commands 1 (reset state) and 5 (close) close the window and return code 1. They leave the argument bytes untouched.
- R9: Any command code other than 1 to 9 returns code 2 and leaves the window unchanged.
- R10: Host writes to byte 15 have no effect. `evt_set` ORs its bits into byte 15. Command 9 clears the byte-15 bits set in argument 0 and returns code 1. A bit set by `evt_set` in the response cycle survives a clear of the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_waddr | input | 4 | Host write byte index |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 4 | Host read byte index |
| host_rdata | output | 8 | Mailbox byte at `host_raddr` (combinational) |
| host_bell | input | 1 | Doorbell from host |
| evt_set | input | 8 | Event bits to set in byte 15 |
| host_irq | output | 1 | One-cycle response interrupt to host |
| busy | output | 1 | Request in progress |

## Verification
Two functions can act in the same cycle. The first pair is the acknowledge clear of byte 15 and a management event set; the bench drives `evt_set` in exactly the response cycle of an acknowledge that clears the same bit, and expects the bit to remain set. The second pair is a host write to byte 1 and the echoed sequence number landing on the same edge; the bench expects the captured sequence to win. A second doorbell is also issued in that same busy cycle, and the bench judges it ignored when no second interrupt pulse follows.

// File: rtl/mbx_pkg.sv
// Package: shared constants and types for the mailbox responder.
// Assumes a 16-byte mailbox with fixed byte roles; command and response
// code values are fixed by the host protocol.
package mbx_pkg;
    localparam int MB_BYTES  = 16;
    localparam int ARG_N     = 11;
    localparam int BYTE_CMD  = 0;
    localparam int BYTE_SEQ  = 1;
    localparam int BYTE_ARG0 = 2;
    localparam int BYTE_CODE = 13;
    localparam int BYTE_EVT  = 15;
    localparam int REQ_TOP   = BYTE_ARG0 + ARG_N - 1;

    localparam logic [7:0] OP_RESET      = 8'd1;
    localparam logic [7:0] OP_MBOX_INFO  = 8'd2;
    localparam logic [7:0] OP_FLASH_INFO = 8'd3;
    localparam logic [7:0] OP_OPEN_RD    = 8'd4;
    localparam logic [7:0] OP_CLOSE      = 8'd5;
    localparam logic [7:0] OP_OPEN_WR    = 8'd6;
    localparam logic [7:0] OP_DIRTY      = 8'd7;
    localparam logic [7:0] OP_FLUSH      = 8'd8;
    localparam logic [7:0] OP_EVT_ACK    = 8'd9;

    localparam logic [7:0] RC_OK    = 8'd1;
    localparam logic [7:0] RC_PARAM = 8'd2;

    typedef struct packed {
        logic        open;
        logic        wr;
        logic [15:0] off;
    } win_t;

    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RING} st_e;
endpackage

// File: rtl/mbx_bytes.sv
// Module: mailbox byte store. Holds the 16 bytes.
// Per byte, a response write takes priority over a host write in the same cycle.
// The event byte ignores host writes. It merges a clear mask from the responder
// with set bits from management logic, and a set wins over a clear.
module mbx_bytes
    import mbx_pkg::*;
#(
    parameter logic [7:0] EVT_RST = 8'h01
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_we,
    input  logic [3:0]                host_waddr,
    input  logic [7:0]                host_wdata,
    input  logic                      rsp_we,
    input  logic [7:0]                rsp_seq,
    input  logic [7:0]                rsp_code,
    input  logic [ARG_N-1:0][7:0]     rsp_args,
    input  logic [ARG_N-1:0]          rsp_mask,
    input  logic [7:0]                evt_clr,
    input  logic [7:0]                evt_set,
    output logic [MB_BYTES-1:0][7:0]  mb_q
);
    for (genvar g = 0; g < MB_BYTES; g++) begin : g_byte
        if (g == BYTE_EVT) begin : g_evt
            logic [7:0] clr_eff;
            assign clr_eff = rsp_we ? evt_clr : 8'h00;
            // Event byte: clear acknowledged bits, then OR in new events.
            always_ff @(posedge clk) begin
                if (!rst_n) mb_q[g] <= EVT_RST;
                else        mb_q[g] <= (mb_q[g] & ~clr_eff) | evt_set;
            end
        end else begin : g_gen
            logic       fsm_hit;
            logic [7:0] fsm_val;
            if (g == BYTE_SEQ) begin : g_seq
                assign fsm_hit = rsp_we;
                assign fsm_val = rsp_seq;
            end else if (g == BYTE_CODE) begin : g_code
                assign fsm_hit = rsp_we;
                assign fsm_val = rsp_code;
            end else if (g >= BYTE_ARG0 && g < BYTE_ARG0 + ARG_N) begin : g_arg
                assign fsm_hit = rsp_we & rsp_mask[g-BYTE_ARG0];
                assign fsm_val = rsp_args[g-BYTE_ARG0];
            end else begin : g_host
                assign fsm_hit = 1'b0;
                assign fsm_val = 8'h00;
            end
            // General byte: responder write first, else host write.
            always_ff @(posedge clk) begin
                if (!rst_n)                             mb_q[g] <= 8'h00;
                else if (fsm_hit)                       mb_q[g] <= fsm_val;
                else if (host_we && host_waddr == 4'(g)) mb_q[g] <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/mbx_exec.sv
// Module: combinational command decoder and response builder.
// Works on the request copy taken at the doorbell edge.
// Produces the response arguments and their write mask, the code, the next
// window record and the event clear mask. Assumes a single window.
module mbx_exec
    import mbx_pkg::*;
#(
    parameter int FLASH_BLKS   = 1024,
    parameter int BLK_SHIFT    = 12,
    parameter int RD_WIN_BLKS  = 256,
    parameter int WR_WIN_BLKS  = 128,
    parameter int ERASE_BYTES  = 4096,
    parameter int API_VER      = 1,
    parameter int LPC_BASE_BLK = 'h0F00
) (
    input  logic [7:0]            cmd,
    input  logic [ARG_N-1:0][7:0] args,
    input  win_t                  win_q,
    output logic [7:0]            code,
    output logic [ARG_N-1:0][7:0] rsp_args,
    output logic [ARG_N-1:0]      rsp_mask,
    output win_t                  win_d,
    output logic [7:0]            evt_clr
);
    localparam logic [31:0] FLASH_BYTES = 32'(FLASH_BLKS) << BLK_SHIFT;
    localparam logic [31:0] ERASE_W     = 32'(ERASE_BYTES);
    localparam logic [15:0] RD_W        = 16'(RD_WIN_BLKS);
    localparam logic [15:0] WR_W        = 16'(WR_WIN_BLKS);
    localparam logic [15:0] BASE_W      = 16'(LPC_BASE_BLK);

    logic [15:0] req_off;
    logic [15:0] pos;
    logic        off_ok;
    assign req_off = {args[1], args[0]};
    assign pos     = req_off + BASE_W;
    assign off_ok  = 32'(req_off) < 32'(FLASH_BLKS);

    // Decode the command and build every response field.
    always_comb begin
        code     = RC_PARAM;
        rsp_args = '0;
        rsp_mask = '0;
        win_d    = win_q;
        evt_clr  = 8'h00;
        case (cmd)
            OP_RESET, OP_CLOSE: begin
                win_d.open = 1'b0;
                win_d.wr   = 1'b0;
                code       = RC_OK;
            end
            OP_MBOX_INFO: begin
                rsp_args[0] = 8'(API_VER);
                rsp_args[1] = RD_W[7:0];
                rsp_args[2] = RD_W[15:8];
                rsp_args[3] = WR_W[7:0];
                rsp_args[4] = WR_W[15:8];
                rsp_args[5] = 8'(BLK_SHIFT);
                for (int i = 0; i < 6; i++) rsp_mask[i] = 1'b1;
                code = RC_OK;
            end
            OP_FLASH_INFO: begin
                for (int i = 0; i < 4; i++) begin
                    rsp_args[i]   = FLASH_BYTES[8*i +: 8];
                    rsp_args[i+4] = ERASE_W[8*i +: 8];
                    rsp_mask[i]   = 1'b1;
                    rsp_mask[i+4] = 1'b1;
                end
                code = RC_OK;
            end
            OP_OPEN_RD, OP_OPEN_WR: begin
                if (off_ok) begin
                    win_d.open  = 1'b1;
                    win_d.wr    = (cmd == OP_OPEN_WR);
                    win_d.off   = req_off;
                    rsp_args[0] = pos[7:0];
                    rsp_args[1] = pos[15:8];
                    rsp_mask[0] = 1'b1;
                    rsp_mask[1] = 1'b1;
                    code        = RC_OK;
                end
            end
            OP_DIRTY, OP_FLUSH: begin
                if (win_q.open && win_q.wr) code = RC_OK;
            end
            OP_EVT_ACK: begin
                evt_clr = args[0];
                code    = RC_OK;
            end
            default: code = RC_PARAM;
        endcase
    end
endmodule

// File: rtl/mbx_ctrl.sv
// Module: request sequencer. IDLE takes a copy of bytes 0..12 on a doorbell.
// EXEC commits the response and the window update in one edge. RING drives
// the host interrupt for one cycle. Doorbells outside IDLE are ignored.
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int FLASH_BLKS   = 1024,
    parameter int BLK_SHIFT    = 12,
    parameter int RD_WIN_BLKS  = 256,
    parameter int WR_WIN_BLKS  = 128,
    parameter int ERASE_BYTES  = 4096,
    parameter int API_VER      = 1,
    parameter int LPC_BASE_BLK = 'h0F00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_bell,
    input  logic [REQ_TOP:0][7:0]   req_bytes,
    output logic                    busy,
    output logic                    host_irq,
    output logic                    rsp_we,
    output logic [7:0]              rsp_seq,
    output logic [7:0]              rsp_code,
    output logic [ARG_N-1:0][7:0]   rsp_args,
    output logic [ARG_N-1:0]        rsp_mask,
    output logic [7:0]              evt_clr
);
    st_e                   st_q;
    logic [7:0]            cmd_q;
    logic [7:0]            seq_q;
    logic [ARG_N-1:0][7:0] args_q;
    win_t                  win_q;
    win_t                  win_d;

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else begin
            case (st_q)
                ST_IDLE: if (host_bell) st_q <= ST_EXEC;
                ST_EXEC: st_q <= ST_RING;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Request copy, taken only on an accepted doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= 8'h00;
            seq_q  <= 8'h00;
            args_q <= '0;
        end else if (st_q == ST_IDLE && host_bell) begin
            cmd_q  <= req_bytes[BYTE_CMD];
            seq_q  <= req_bytes[BYTE_SEQ];
            args_q <= req_bytes[REQ_TOP:BYTE_ARG0];
        end
    end

    // Window record, committed together with the response.
    always_ff @(posedge clk) begin
        if (!rst_n)              win_q <= '0;
        else if (st_q == ST_EXEC) win_q <= win_d;
    end

    mbx_exec #(
        .FLASH_BLKS  (FLASH_BLKS),
        .BLK_SHIFT   (BLK_SHIFT),
        .RD_WIN_BLKS (RD_WIN_BLKS),
        .WR_WIN_BLKS (WR_WIN_BLKS),
        .ERASE_BYTES (ERASE_BYTES),
        .API_VER     (API_VER),
        .LPC_BASE_BLK(LPC_BASE_BLK)
    ) u_exec (
        .cmd     (cmd_q),
        .args    (args_q),
        .win_q   (win_q),
        .code    (rsp_code),
        .rsp_args(rsp_args),
        .rsp_mask(rsp_mask),
        .win_d   (win_d),
        .evt_clr (evt_clr)
    );

    assign rsp_we   = (st_q == ST_EXEC);
    assign rsp_seq  = seq_q;
    assign host_irq = (st_q == ST_RING);
    assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/mbx_responder.sv
// Module: top of the mailbox responder. Joins the byte store and the
// sequencer. The host read port is a combinational byte select.
// Assumes single-cycle pulses on host_bell and evt_set.
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int FLASH_BLKS   = 1024,
    parameter int BLK_SHIFT    = 12,
    parameter int RD_WIN_BLKS  = 256,
    parameter int WR_WIN_BLKS  = 128,
    parameter int ERASE_BYTES  = 4096,
    parameter int API_VER      = 1,
    parameter int LPC_BASE_BLK = 'h0F00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [3:0] host_waddr,
    input  logic [7:0] host_wdata,
    input  logic [3:0] host_raddr,
    output logic [7:0] host_rdata,
    input  logic       host_bell,
    input  logic [7:0] evt_set,
    output logic       host_irq,
    output logic       busy
);
    logic [MB_BYTES-1:0][7:0] mb_q;
    logic                     rsp_we;
    logic [7:0]               rsp_seq;
    logic [7:0]               rsp_code;
    logic [ARG_N-1:0][7:0]    rsp_args;
    logic [ARG_N-1:0]         rsp_mask;
    logic [7:0]               evt_clr;

    mbx_bytes #(.EVT_RST(8'h01)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_waddr(host_waddr),
        .host_wdata(host_wdata),
        .rsp_we    (rsp_we),
        .rsp_seq   (rsp_seq),
        .rsp_code  (rsp_code),
        .rsp_args  (rsp_args),
        .rsp_mask  (rsp_mask),
        .evt_clr   (evt_clr),
        .evt_set   (evt_set),
        .mb_q      (mb_q)
    );

    mbx_ctrl #(
        .FLASH_BLKS  (FLASH_BLKS),
        .BLK_SHIFT   (BLK_SHIFT),
        .RD_WIN_BLKS (RD_WIN_BLKS),
        .WR_WIN_BLKS (WR_WIN_BLKS),
        .ERASE_BYTES (ERASE_BYTES),
        .API_VER     (API_VER),
        .LPC_BASE_BLK(LPC_BASE_BLK)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_bell(host_bell),
        .req_bytes(mb_q[REQ_TOP:0]),
        .busy     (busy),
        .host_irq (host_irq),
        .rsp_we   (rsp_we),
        .rsp_seq  (rsp_seq),
        .rsp_code (rsp_code),
        .rsp_args (rsp_args),
        .rsp_mask (rsp_mask),
        .evt_clr  (evt_clr)
    );

    assign host_rdata = mb_q[host_raddr];
endmodule

// File: rtl/mbx_responder_chk.sv
// Module: protocol checker for mbx_responder, attached by bind.
// Watches the interrupt pulse, doorbell acceptance, the response code byte
// and the event byte.
module mbx_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_irq,
    input logic       busy,
    input logic       host_bell,
    input logic       host_we,
    input logic [3:0] host_waddr,
    input logic [7:0] evt_set,
    input logic [7:0] evt_byte,
    input logic [7:0] code_byte
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq); // R2
    AST_BELL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_bell) |=> busy); // R2
    AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(busy)); // R2
    AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !busy); // R2
    AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (code_byte >= 8'd1 && code_byte <= 8'd5)); // R3
    AST_EVT_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 8'h00) |=> ((evt_byte & $past(evt_set)) == $past(evt_set))); // R10
    AST_EVT_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_waddr == 4'd15 && evt_set == 8'h00 && !busy) |=> $stable(evt_byte)); // R10
endmodule

bind mbx_responder mbx_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_irq  (host_irq),
    .busy      (busy),
    .host_bell (host_bell),
    .host_we   (host_we),
    .host_waddr(host_waddr),
    .evt_set   (evt_set),
    .evt_byte  (mb_q[15]),
    .code_byte (mb_q[13])
);

// File: tb/mbx_responder_test.sv
// Bench: table-driven command walk, then directed reset, info, event and
// same-cycle tests. Inputs change and outputs are sampled on falling edges.
module mbx_responder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_waddr = 4'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [3:0] host_raddr = 4'd0;
    logic [7:0] host_rdata;
    logic       host_bell = 1'b0;
    logic [7:0] evt_set = 8'h00;
    logic       host_irq;
    logic       busy;
    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] v;

    always #10 clk = ~clk; // 50 MHz

    mbx_responder uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .host_bell(host_bell), .evt_set(evt_set), .host_irq(host_irq), .busy(busy)
    );

    // Fields: cmd, seq, arg0, arg1, expected code, expected arg0, expected arg1
    localparam int NV = 17;
    localparam logic [55:0] VEC [NV] = '{
        56'h07_11_00_00_02_00_00, // R7 mark dirty, no window
        56'h06_12_05_00_01_05_0F, // R6 open write at 5 -> 0x0F05
        56'h07_13_00_00_01_00_00, // R7 dirty with write window
        56'h0A_14_00_00_02_00_00, // R9 unknown code
        56'h08_15_00_00_01_00_00, // R9 window kept; R7 flush ok
        56'h06_16_00_04_02_00_04, // R6 offset 1024 rejected, args untouched
        56'h07_17_00_00_01_00_00, // R6 window kept after reject
        56'h06_18_FF_03_01_FF_12, // R6 last block 1023 -> 0x12FF
        56'h04_19_10_00_01_10_0F, // R6 read window replaces write
        56'h07_1A_00_00_02_00_00, // R7 read window refuses dirty
        56'h06_1B_00_00_01_00_0F, // R6 offset 0
        56'h05_1C_33_44_01_33_44, // R8 close, args untouched
        56'h08_1D_00_00_02_00_00, // R8 closed -> flush refused
        56'h06_1E_02_00_01_02_0F, // R6 reopen
        56'h01_1F_00_00_01_00_00, // R8 reset state closes
        56'h07_20_00_00_02_00_00, // R8 closed after reset state
        56'h00_21_00_00_02_00_00  // R9 code zero
    };

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [7:0] d);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    // Rings the doorbell and stops in the interrupt cycle.
    task automatic ring_to_irq();
        host_bell = 1'b1;
        @(negedge clk);
        host_bell = 1'b0;
        chk8("R2 irq low in exec", {7'd0, host_irq}, 8'h00);
        chk8("R2 busy in exec", {7'd0, busy}, 8'h01);
        @(negedge clk);
        chk8("R2 irq pulse", {7'd0, host_irq}, 8'h01);
    endtask

    task automatic after_irq();
        @(negedge clk);
        chk8("R2 irq single", {7'd0, host_irq}, 8'h00);
        chk8("R2 busy cleared", {7'd0, busy}, 8'h00);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'd15, v); chk8("R1 event byte", v, 8'h01);
        rd(4'd13, v); chk8("R1 code byte", v, 8'h00);
        rd(4'd1, v);  chk8("R1 seq byte", v, 8'h00);
        chk8("R1 irq", {7'd0, host_irq}, 8'h00);
        chk8("R1 busy", {7'd0, busy}, 8'h00);
        // R1 no window open: flush refused
        hwr(4'd0, 8'h08); hwr(4'd1, 8'h01);
        ring_to_irq();
        rd(4'd13, v); chk8("R1 no window after reset", v, 8'h02);
        after_irq();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            hwr(4'd0, VEC[i][55:48]);
            hwr(4'd1, VEC[i][47:40]);
            hwr(4'd2, VEC[i][39:32]);
            hwr(4'd3, VEC[i][31:24]);
            hwr(4'd13, 8'hEE);
            ring_to_irq();
            rd(4'd13, v); chk8($sformatf("R3/R6-R9 code vec %0d", i), v, VEC[i][23:16]);
            rd(4'd1, v);  chk8($sformatf("R3 seq vec %0d", i), v, VEC[i][47:40]);
            rd(4'd2, v);  chk8($sformatf("R6 arg0 vec %0d", i), v, VEC[i][15:8]);
            rd(4'd3, v);  chk8($sformatf("R6 arg1 vec %0d", i), v, VEC[i][7:0]);
            after_irq();
        end

        // R4 mailbox info
        hwr(4'd0, 8'h02); hwr(4'd1, 8'h40);
        ring_to_irq();
        rd(4'd13, v); chk8("R4 code", v, 8'h01);
        rd(4'd2, v); chk8("R4 api", v, 8'h01);
        rd(4'd3, v); chk8("R4 rd lo", v, 8'h00);
        rd(4'd4, v); chk8("R4 rd hi", v, 8'h01);
        rd(4'd5, v); chk8("R4 wr lo", v, 8'h80);
        rd(4'd6, v); chk8("R4 wr hi", v, 8'h00);
        rd(4'd7, v); chk8("R4 blk shift", v, 8'h0C);
        after_irq();

        // R5 flash info: 4 MiB and 4 KiB, least significant byte first
        hwr(4'd0, 8'h03); hwr(4'd1, 8'h41);
        ring_to_irq();
        rd(4'd13, v); chk8("R5 code", v, 8'h01);
        rd(4'd2, v); chk8("R5 size b0", v, 8'h00);
        rd(4'd3, v); chk8("R5 size b1", v, 8'h00);
        rd(4'd4, v); chk8("R5 size b2", v, 8'h40);
        rd(4'd5, v); chk8("R5 size b3", v, 8'h00);
        rd(4'd6, v); chk8("R5 erase b0", v, 8'h00);
        rd(4'd7, v); chk8("R5 erase b1", v, 8'h10);
        rd(4'd8, v); chk8("R5 erase b2", v, 8'h00);
        rd(4'd9, v); chk8("R5 erase b3", v, 8'h00);
        after_irq();

        // R10 host write to event byte ignored
        hwr(4'd15, 8'hAA);
        rd(4'd15, v); chk8("R10 host write ignored", v, 8'h01);
        // R10 event set ORs in
        evt_set = 8'h06;
        @(negedge clk);
        evt_set = 8'h00;
        rd(4'd15, v); chk8("R10 event set", v, 8'h07);
        // R10 acknowledge clears bits 0 and 2
        hwr(4'd0, 8'h09); hwr(4'd1, 8'h42); hwr(4'd2, 8'h05);
        ring_to_irq();
        rd(4'd13, v); chk8("R10 ack code", v, 8'h01);
        rd(4'd15, v); chk8("R10 ack clear", v, 8'h02);
        after_irq();
        // R10 same cycle: ack clears bits 0-1 while bit 0 is set again
        hwr(4'd0, 8'h09); hwr(4'd1, 8'h43); hwr(4'd2, 8'h03);
        host_bell = 1'b1;
        @(negedge clk);
        host_bell = 1'b0;
        evt_set = 8'h01;
        @(negedge clk);
        evt_set = 8'h00;
        chk8("R2 irq in collision run", {7'd0, host_irq}, 8'h01);
        rd(4'd15, v); chk8("R10 set beats clear", v, 8'h01);
        after_irq();

        // R3/R2 host write to seq byte and a second doorbell in the response cycle
        hwr(4'd0, 8'h07); hwr(4'd1, 8'h55);
        host_bell = 1'b1;
        @(negedge clk);
        host_bell = 1'b1;
        host_we = 1'b1; host_waddr = 4'd1; host_wdata = 8'h99;
        @(negedge clk);
        host_bell = 1'b0;
        host_we = 1'b0;
        chk8("R2 irq with busy doorbell", {7'd0, host_irq}, 8'h01);
        rd(4'd1, v); chk8("R3 seq wins over host write", v, 8'h55);
        after_irq();
        @(negedge clk);
        chk8("R2 busy doorbell ignored irq", {7'd0, host_irq}, 8'h00);
        chk8("R2 busy doorbell ignored busy", {7'd0, busy}, 8'h00);

        finish_run();
    end
endmodule